// File: doc/BRIEF.md
# Serial-Access Configuration Register File

This block is the slave-side register bank of a two-channel converter. A host reaches it over a four-wire serial link: chip select (active low), serial clock, data in and data out. Every chip-select frame opens with a command byte. That byte names a device, a starting register and a direction. Each later byte in the same frame is either written to the current register or read from it, and the register pointer then steps to the next address. A host can therefore load every writable setting, including the converter reset field, in a single frame.

The register map has twelve byte locations. Addresses 0x00 to 0x05 hold the latest samples of the two channels, three bytes per channel with the most significant byte first. These are read-only and come from input ports. Addresses 0x06 to 0x0B hold six writable settings: modulator, phase, gain, status, and two configuration bytes, all cleared by reset. The second configuration byte also drives the per-channel reset field and the per-channel shutdown field of the converters.

The serial pins are sampled by the system clock through a synchronizer. The serial clock must therefore stay well below the system clock rate: each serial clock level must last at least SYNC_STAGES + 3 system clock cycles.

Top module: `cfgspi_regfile`

## Requirements
- R1: After reset, all six writable registers read 0x00, `adc_hold` and `adc_off` are 2'b00, and `miso` is 0.
- R2: The command byte is taken MSB first. Its bits [7:6] must equal the parameter DEV_ID (default 2'b01), its bits [5:1] give the start address, and its bit 0 gives the direction (1 = read, 0 = write). When the device bits do not match, the rest of the frame is ignored: no register changes and `miso` stays 0.
- R3: In a write frame, each complete byte after the command is stored at the current address. Data bits are sampled MSB first on rising SCK edges.
- R4: The address advances by one after every data byte in a read or write frame, and wraps from 0x0B to 0x00. A burst that starts at 0x07 therefore fills phase, gain, status, config 1 and config 2 in order.
- R5: In a read frame, the byte at the current address is loaded on the SCK falling edge that follows the last bit of the previous byte. It is presented on `miso` MSB first and advances one bit on each later falling edge. Successive bytes come from successive addresses.
- R6: Addresses 0x00–0x02 return `ch0_sample` bits [23:16], [15:8] and [7:0] in that order, and 0x03–0x05 return `ch1_sample` in the same way. A write to any of these addresses changes nothing, but the address still advances.
- R7: Addresses 0x0C–0x1F read as 0x00, and writes to them are discarded.
- R8: Raising `cs_n` discards any partly received byte and returns the block to the command phase. The next frame is decoded from its first bit.
- R9: `adc_hold` equals config 2 (address 0x0B) bits [7:6], where 2'b11 holds both converters in reset. `adc_off` equals config 2 bits [5:4].
- R10: `miso` is 0 whenever `cs_n` is high, or when the frame is not an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| ch0_sample | input | 24 | Latest channel 0 conversion result |
| ch1_sample | input | 24 | Latest channel 1 conversion result |
| mod_reg | output | 8 | Modulator setting (address 0x06) |
| phase_reg | output | 8 | Phase setting (address 0x07) |
| gain_reg | output | 8 | Gain setting (address 0x08) |
| status_reg | output | 8 | Status/communication setting (address 0x09) |
| cfg1_reg | output | 8 | Configuration 1 (address 0x0A) |
| cfg2_reg | output | 8 | Configuration 2 (address 0x0B) |
| adc_hold | output | 2 | Per-channel converter reset, config 2 bits [7:6] |
| adc_off | output | 2 | Per-channel converter shutdown, config 2 bits [5:4] |

## Verification
Each serial edge reaches the logic SYNC_STAGES system cycles after it appears on a pin, plus one cycle for edge detection. A written register therefore changes SYNC_STAGES + 2 cycles after the eighth rising SCK edge of its byte. A new `miso` bit appears SYNC_STAGES + 2 cycles after the falling edge that loads or shifts it. The bench holds each SCK level for eight system cycles. It samples `miso` just before it raises SCK, and it reads register outputs only after a frame has closed and sixteen more cycles have passed, so every result has settled before it is compared. The checker compares cycle-exact relations one cycle after each internal byte event.

// File: rtl/cfgspi_pkg.sv
package cfgspi_pkg;
  localparam int ADDR_W    = 5;
  localparam int BYTE_W    = 8;
  localparam int CH_BYTES  = 3;
  localparam int SAMPLE_W  = CH_BYTES * BYTE_W;
  localparam int N_CFG     = 6;
  localparam int FIRST_CFG = 2 * CH_BYTES;
  localparam int LAST_ADDR = FIRST_CFG + N_CFG - 1;
  localparam int IDX_MOD   = 0;
  localparam int IDX_PHASE = 1;
  localparam int IDX_GAIN  = 2;
  localparam int IDX_STAT  = 3;
  localparam int IDX_CFG1  = 4;
  localparam int IDX_CFG2  = 5;
  localparam int IDX_W     = $clog2(N_CFG);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [IDX_W-1:0]  cfg_idx_t;

  typedef enum logic [1:0] {PH_CMD, PH_WRITE, PH_READ, PH_IGNORE} phase_e;

  function automatic addr_t next_addr(addr_t a);
    return (a == addr_t'(LAST_ADDR)) ? '0 : a + addr_t'(1);
  endfunction

  function automatic logic is_cfg(addr_t a);
    return (a >= addr_t'(FIRST_CFG)) && (a <= addr_t'(LAST_ADDR));
  endfunction

  function automatic logic is_data(addr_t a);
    return a < addr_t'(FIRST_CFG);
  endfunction

  function automatic cfg_idx_t cfg_idx(addr_t a);
    addr_t d;
    d = a - addr_t'(FIRST_CFG);
    return d[IDX_W-1:0];
  endfunction

  function automatic logic [1:0] cmd_dev(byte_t b);
    return b[7:6];
  endfunction

  function automatic addr_t cmd_addr(byte_t b);
    return b[5:1];
  endfunction

  function automatic logic cmd_is_read(byte_t b);
    return b[0];
  endfunction

  // Byte k (0 = most significant) of a channel sample
  function automatic byte_t sample_byte(logic [SAMPLE_W-1:0] s, int unsigned k);
    return s[BYTE_W*(CH_BYTES-1-k) +: BYTE_W];
  endfunction
endpackage

// File: rtl/cfgspi_sync.sv
module cfgspi_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cfgspi_shifter.sv
module cfgspi_shifter
  import cfgspi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs_idle,
  input  logic  sck_rise,
  input  logic  sck_fall,
  input  logic  mosi_bit,
  input  logic  load_en,
  input  byte_t load_data,
  output logic  byte_done,
  output byte_t rx_byte,
  output logic  tx_bit
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0] bit_cnt;
  byte_t            shin_q;
  byte_t            shout_q;

  assign byte_done = sck_rise && !cs_idle && (bit_cnt == CNT_W'(BYTE_W - 1));
  assign rx_byte   = {shin_q[BYTE_W-2:0], mosi_bit};
  assign tx_bit    = shout_q[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shin_q  <= '0;
      shout_q <= '0;
    end else if (cs_idle) begin
      bit_cnt <= '0;
      shout_q <= '0;
    end else begin
      if (sck_rise) begin
        shin_q  <= rx_byte;
        bit_cnt <= bit_cnt + CNT_W'(1);
      end
      if (sck_fall) begin
        shout_q <= load_en ? load_data : {shout_q[BYTE_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/cfgspi_regbank.sv
module cfgspi_regbank
  import cfgspi_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  addr_t               addr,
  input  byte_t               wdata,
  input  logic [SAMPLE_W-1:0] ch0,
  input  logic [SAMPLE_W-1:0] ch1,
  output byte_t               rdata,
  output byte_t               cfg_q [N_CFG],
  output logic                wr_drop
);
  logic     wr_commit;
  cfg_idx_t wr_idx;

  assign wr_commit = wr_en && is_cfg(addr);
  assign wr_drop   = wr_en && !is_cfg(addr);
  assign wr_idx    = cfg_idx(addr);

  for (genvar k = 0; k < N_CFG; k++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[k] <= '0;
      else if (wr_commit && (wr_idx == cfg_idx_t'(k))) cfg_q[k] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (is_data(addr)) begin
      if (addr < addr_t'(CH_BYTES)) rdata = sample_byte(ch0, int'(addr));
      else rdata = sample_byte(ch1, int'(addr) - CH_BYTES);
    end else if (is_cfg(addr)) begin
      rdata = cfg_q[wr_idx];
    end
  end
endmodule

// File: rtl/cfgspi_regfile.sv
module cfgspi_regfile
  import cfgspi_pkg::*;
#(
  parameter logic [1:0] DEV_ID = 2'b01,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sck,
  input  logic                mosi,
  output logic                miso,
  input  logic [SAMPLE_W-1:0] ch0_sample,
  input  logic [SAMPLE_W-1:0] ch1_sample,
  output logic [BYTE_W-1:0]   mod_reg,
  output logic [BYTE_W-1:0]   phase_reg,
  output logic [BYTE_W-1:0]   gain_reg,
  output logic [BYTE_W-1:0]   status_reg,
  output logic [BYTE_W-1:0]   cfg1_reg,
  output logic [BYTE_W-1:0]   cfg2_reg,
  output logic [1:0]          adc_hold,
  output logic [1:0]          adc_off
);
  // synchronized pins
  logic cs_n_s, sck_s, mosi_s, sck_prev;
  logic cs_idle, sck_rise, sck_fall;

  cfgspi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n, sck, mosi}),
    .q({cs_n_s, sck_s, mosi_s})
  );

  assign cs_idle  = cs_n_s;
  assign sck_rise = sck_s && !sck_prev;
  assign sck_fall = !sck_s && sck_prev;

  // named internal events
  phase_e phase;
  addr_t  cur_addr;
  logic   rd_pending;
  logic   byte_done, cmd_byte, cmd_accept, wr_req, rd_advance, load_rd, load_en;
  logic   wr_drop, tx_bit;
  byte_t  rx_byte, rdata;
  byte_t  cfg_q [N_CFG];
  logic [N_CFG*BYTE_W-1:0] cfg_flat;

  assign cmd_byte   = byte_done && (phase == PH_CMD);
  assign cmd_accept = cmd_byte && (cmd_dev(rx_byte) == DEV_ID);
  assign wr_req     = byte_done && (phase == PH_WRITE);
  assign rd_advance = byte_done && (phase == PH_READ);
  assign load_rd    = (cmd_accept && cmd_is_read(rx_byte)) || rd_advance;
  assign load_en    = sck_fall && rd_pending;

  cfgspi_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_bit(mosi_s),
    .load_en(load_en), .load_data(rdata),
    .byte_done(byte_done), .rx_byte(rx_byte), .tx_bit(tx_bit)
  );

  cfgspi_regbank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_req), .addr(cur_addr), .wdata(rx_byte),
    .ch0(ch0_sample), .ch1(ch1_sample), .rdata(rdata), .cfg_q(cfg_q),
    .wr_drop(wr_drop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_CMD;
      cur_addr   <= '0;
      rd_pending <= 1'b0;
      sck_prev   <= 1'b0;
    end else begin
      sck_prev <= sck_s;
      if (cs_idle) begin
        phase      <= PH_CMD;
        rd_pending <= 1'b0;
      end else begin
        if (cmd_byte) begin
          if (!cmd_accept) phase <= PH_IGNORE;
          else if (cmd_is_read(rx_byte)) phase <= PH_READ;
          else phase <= PH_WRITE;
        end
        if (cmd_accept) cur_addr <= cmd_addr(rx_byte);
        else if (wr_req || rd_advance) cur_addr <= next_addr(cur_addr);
        if (load_rd) rd_pending <= 1'b1;
        else if (sck_fall) rd_pending <= 1'b0;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < N_CFG; k++) cfg_flat[k*BYTE_W +: BYTE_W] = cfg_q[k];
  end

  assign miso       = !cs_n && (phase == PH_READ) && tx_bit;
  assign mod_reg    = cfg_q[IDX_MOD];
  assign phase_reg  = cfg_q[IDX_PHASE];
  assign gain_reg   = cfg_q[IDX_GAIN];
  assign status_reg = cfg_q[IDX_STAT];
  assign cfg1_reg   = cfg_q[IDX_CFG1];
  assign cfg2_reg   = cfg_q[IDX_CFG2];
  assign adc_hold   = cfg_q[IDX_CFG2][7:6];
  assign adc_off    = cfg_q[IDX_CFG2][5:4];
endmodule

// File: rtl/cfgspi_checker.sv
module cfgspi_checker
  import cfgspi_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cs_n,
  input logic                    miso,
  input logic                    cs_idle,
  input logic                    byte_done,
  input logic                    cmd_accept,
  input logic                    wr_req,
  input logic                    rd_advance,
  input logic                    wr_drop,
  input phase_e                  phase,
  input addr_t                   cur_addr,
  input byte_t                   rx_byte,
  input logic [N_CFG*BYTE_W-1:0] cfg_flat,
  input logic [1:0]              adc_hold,
  input logic [1:0]              adc_off
);
  logic     after_rst;
  logic     wr_seen;
  cfg_idx_t wr_idx;
  byte_t    wr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      after_rst <= 1'b1;
      wr_seen   <= 1'b0;
      wr_idx    <= '0;
      wr_val    <= '0;
    end else begin
      after_rst <= 1'b0;
      wr_seen   <= wr_req && is_cfg(cur_addr);
      wr_idx    <= cfg_idx(cur_addr);
      wr_val    <= rx_byte;
    end
  end

  assert_defaults_R1: assert property (@(posedge clk) disable iff (!rst_n)
    after_rst |-> (cfg_flat == '0 && adc_hold == 2'b00 && adc_off == 2'b00 && !miso));

  assert_ignored_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IGNORE) |-> !miso);

  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_seen |-> (cfg_flat[BYTE_W*wr_idx +: BYTE_W] == wr_val));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req || rd_advance) |=> (cur_addr == next_addr($past(cur_addr))));

  assert_addr_still_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_accept || wr_req || rd_advance) |=> $stable(cur_addr));

  assert_one_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_accept, wr_req, rd_advance}));

  assert_drop_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> $stable(cfg_flat));

  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |-> !byte_done);

  assert_hold_field_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && cur_addr == addr_t'(LAST_ADDR)) |=>
      (adc_hold == $past(rx_byte[7:6]) && adc_off == $past(rx_byte[5:4])));

  assert_miso_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !miso);
endmodule

bind cfgspi_regfile cfgspi_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso), .cs_idle(cs_idle),
  .byte_done(byte_done), .cmd_accept(cmd_accept), .wr_req(wr_req),
  .rd_advance(rd_advance), .wr_drop(wr_drop), .phase(phase),
  .cur_addr(cur_addr), .rx_byte(rx_byte), .cfg_flat(cfg_flat),
  .adc_hold(adc_hold), .adc_off(adc_off)
);

// File: tb/sim_cfgspi_regfile.sv
`timescale 1ns/1ps
module sim_cfgspi_regfile;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso;
  logic [23:0] ch0_sample = '0, ch1_sample = '0;
  logic [7:0] mod_reg, phase_reg, gain_reg, status_reg, cfg1_reg, cfg2_reg;
  logic [1:0] adc_hold, adc_off;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [7:0] exp_cfg [6];

  always #2.5 clk = ~clk;

  cfgspi_regfile u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso),
    .ch0_sample(ch0_sample), .ch1_sample(ch1_sample),
    .mod_reg(mod_reg), .phase_reg(phase_reg), .gain_reg(gain_reg),
    .status_reg(status_reg), .cfg1_reg(cfg1_reg), .cfg2_reg(cfg2_reg),
    .adc_hold(adc_hold), .adc_off(adc_off)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_cfg(string req);
    check(req, "mod", {24'd0, mod_reg}, {24'd0, exp_cfg[0]});
    check(req, "phase", {24'd0, phase_reg}, {24'd0, exp_cfg[1]});
    check(req, "gain", {24'd0, gain_reg}, {24'd0, exp_cfg[2]});
    check(req, "status", {24'd0, status_reg}, {24'd0, exp_cfg[3]});
    check(req, "cfg1", {24'd0, cfg1_reg}, {24'd0, exp_cfg[4]});
    check(req, "cfg2", {24'd0, cfg2_reg}, {24'd0, exp_cfg[5]});
  endtask

  task automatic frame_start();
    cs_n = 1'b0; sck = 1'b0;
    tick(HALF);
  endtask

  task automatic frame_end();
    tick(HALF);
    cs_n = 1'b1; mosi = 1'b0;
    tick(2*HALF);
  endtask

  // send the top n bits of tx, MSB first; rx collects miso before each rise
  task automatic xfer_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      tick(HALF);
      rx[i] = miso;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xfer_bits(tx, 8, rx);
  endtask

  function automatic logic [7:0] cmd(logic [1:0] dev, logic [4:0] a, logic rd);
    return {dev, a, rd};
  endfunction

  task automatic t_reset();
    check("R1", "adc_hold", {30'd0, adc_hold}, 32'd0);
    check("R1", "adc_off", {30'd0, adc_off}, 32'd0);
    check("R1", "miso", {31'd0, miso}, 32'd0);
    check_cfg("R1");
  endtask

  task automatic t_burst_write();
    logic [7:0] rx;
    logic [7:0] vals [5] = '{8'h5A, 8'h33, 8'h81, 8'h3C, 8'hF0};
    frame_start();
    xfer(cmd(2'b01, 5'h07, 1'b0), rx);
    for (int k = 0; k < 5; k++) begin
      xfer(vals[k], rx);
      exp_cfg[1 + k] = vals[k];
    end
    frame_end();
    check_cfg("R3_R4");
    check("R9", "adc_hold", {30'd0, adc_hold}, {30'd0, exp_cfg[5][7:6]});
    check("R9", "adc_off", {30'd0, adc_off}, {30'd0, exp_cfg[5][5:4]});
  endtask

  task automatic t_read_wrap();
    logic [7:0] rx;
    frame_start();
    xfer(cmd(2'b01, 5'h09, 1'b1), rx);
    check("R10", "miso during command", {24'd0, rx}, 32'd0);
    xfer(8'h00, rx); check("R5", "read 0x09", {24'd0, rx}, {24'd0, exp_cfg[3]});
    xfer(8'h00, rx); check("R5", "read 0x0A", {24'd0, rx}, {24'd0, exp_cfg[4]});
    xfer(8'h00, rx); check("R5", "read 0x0B", {24'd0, rx}, {24'd0, exp_cfg[5]});
    xfer(8'h00, rx); check("R4", "wrap to 0x00", {24'd0, rx}, {24'd0, ch0_sample[23:16]});
    frame_end();
  endtask

  task automatic t_data_read();
    logic [7:0] rx;
    logic [47:0] both;
    both = {ch0_sample, ch1_sample};
    frame_start();
    xfer(cmd(2'b01, 5'h00, 1'b1), rx);
    for (int k = 0; k < 6; k++) begin
      xfer(8'hFF, rx);
      check("R6", "data byte", {24'd0, rx}, {24'd0, both[8*(5-k) +: 8]});
    end
    frame_end();
  endtask

  task automatic t_readonly_write();
    logic [7:0] rx;
    frame_start();
    xfer(cmd(2'b01, 5'h05, 1'b0), rx);
    xfer(8'hFF, rx);
    xfer(8'h11, rx);
    exp_cfg[0] = 8'h11;
    frame_end();
    check_cfg("R6");
    frame_start();
    xfer(cmd(2'b01, 5'h05, 1'b1), rx);
    xfer(8'h00, rx);
    check("R6", "0x05 unchanged", {24'd0, rx}, {24'd0, ch1_sample[7:0]});
    frame_end();
  endtask

  task automatic t_wrong_device();
    logic [7:0] rx;
    frame_start();
    xfer(cmd(2'b10, 5'h07, 1'b0), rx);
    xfer(8'hEE, rx);
    frame_end();
    check_cfg("R2");
    frame_start();
    xfer(cmd(2'b00, 5'h09, 1'b1), rx);
    xfer(8'h00, rx);
    check("R2", "foreign read miso", {24'd0, rx}, 32'd0);
    frame_end();
  endtask

  task automatic t_unmapped();
    logic [7:0] rx;
    frame_start();
    xfer(cmd(2'b01, 5'h0C, 1'b0), rx);
    xfer(8'h77, rx);
    xfer(8'h66, rx);
    frame_end();
    check_cfg("R7");
    frame_start();
    xfer(cmd(2'b01, 5'h0C, 1'b1), rx);
    xfer(8'h00, rx);
    check("R7", "read 0x0C", {24'd0, rx}, 32'd0);
    frame_end();
  endtask

  task automatic t_abort();
    logic [7:0] rx;
    frame_start();
    xfer_bits(8'h4E, 4, rx);
    frame_end();
    frame_start();
    xfer(cmd(2'b01, 5'h07, 1'b0), rx);
    xfer(8'h44, rx);
    exp_cfg[1] = 8'h44;
    frame_end();
    check("R8", "phase after abort", {24'd0, phase_reg}, {24'd0, exp_cfg[1]});
    frame_start();
    xfer(cmd(2'b01, 5'h07, 1'b0), rx);
    xfer_bits(8'hFF, 5, rx);
    frame_end();
    check("R8", "partial byte dropped", {24'd0, phase_reg}, {24'd0, exp_cfg[1]});
    frame_start();
    xfer(cmd(2'b01, 5'h0B, 1'b1), rx);
    xfer_bits(8'h00, 3, rx);
    cs_n = 1'b1;
    tick(1);
    check("R10", "miso after cs high", {31'd0, miso}, 32'd0);
    tick(2*HALF);
  endtask

  task automatic t_wrap_write();
    logic [7:0] rx;
    frame_start();
    xfer(cmd(2'b01, 5'h0B, 1'b0), rx);
    xfer(8'hC0, rx);
    xfer(8'h99, rx);
    xfer(8'h55, rx);
    exp_cfg[5] = 8'hC0;
    frame_end();
    check_cfg("R4");
    check("R9", "adc_hold both", {30'd0, adc_hold}, 32'd3);
    check("R9", "adc_off clear", {30'd0, adc_off}, 32'd0);
    frame_start();
    xfer(cmd(2'b01, 5'h00, 1'b1), rx);
    xfer(8'h00, rx);
    check("R4", "wrapped write dropped", {24'd0, rx}, {24'd0, ch0_sample[23:16]});
    frame_end();
  endtask

  initial begin
    for (int k = 0; k < 6; k++) exp_cfg[k] = 8'h00;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    ch0_sample = 24'hA1B2C3;
    ch1_sample = 24'h0D0E0F;
    t_burst_write();
    t_read_wrap();
    t_data_read();
    t_readonly_write();
    t_wrong_device();
    t_unmapped();
    t_abort();
    t_wrap_write();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule